// File: doc/BRIEF.md
# ACPI Sleep-State Rail Sequencer

This block is the digital heart of a motherboard standby-power controller. It reads two active-high sleep-state pins and turns them into one of three operating states: running, suspend-to-RAM or soft-off. For each of four switchable supply planes (a 3.3 V dual plane, a 5 V dual plane, a memory plane and a clock plane) it drives two path enables. One path takes power from the main supply while the system runs. The other takes power from the standby-derived device while the system sleeps. A fifth output enables the always-present 3.3 V standby rail.

At power-up the block waits a fixed delay after standby power is good. It then captures two configuration straps and a memory-level select, and only after that does it allow any switchable plane to turn on. The straps decide whether each dual plane stays powered in each sleep state. A sticky fault turns every switchable plane off when an enabled rail reports undervoltage. Analog regulation and comparators live outside the block and appear here as digital good or undervoltage flags.

Top module: `acpi_rail_seq`

## Requirements
- R1: The pin code {slp_s5,slp_s3} = 11 selects the running state and 10 selects suspend-to-RAM. 00 selects soft-off. The reserved code 01 leaves the current state unchanged. The state register changes at the clock edge after the pins change, and it resets to soft-off.
- R2: A request for soft-off while in suspend-to-RAM is ignored, and so is a request for suspend-to-RAM while in soft-off. The state only moves between running and one of the sleep states.
- R3: Bit 0 of act_en/slp_en is the 3.3 V dual plane. It uses the active path when running and the sleep path in suspend-to-RAM. In soft-off it uses the sleep path only when the latched strap_d3 is 1, and is off otherwise.
- R4: Bit 1 is the 5 V dual plane. It uses the active path when running. In both sleep states it uses the sleep path only when the latched strap_d5 is 1, and is off otherwise.
- R5: Bit 2 is the memory plane. It uses the active path when running, the sleep path in suspend-to-RAM, and is off in soft-off. mem_hi_v shows the latched mem_sel (1 = higher voltage setting).
- R6: Bit 3 is the clock plane. Its active path is on only in the running state, and its sleep path is never on.
- R7: sb_en follows sb_pgood with one register delay, whatever the sleep pins and straps are.
- R8: While sb_pgood is high, strap_d3, strap_d5 and mem_sel are captured at the WAIT_CYC-th clock edge (WAIT_CYC = CLK_KHZ*DELAY_MS). Until then, and until the next fall of sb_pgood, all path enables stay low. Later changes on the strap pins have no effect.
- R9: No plane ever has both paths enabled at once. When a plane moves between paths, there is at least one cycle in which neither path is enabled.
- R10: Active-path enables are high only while p12_pgood is high. They drop at the clock edge after it falls.
- R11: uv bit i (0..3 as above, bit 4 = standby rail) sets the sticky fault at the next edge if that rail is enabled. While fault is set, all path enables are low. Only reset or sb_pgood low clears the fault.
- R12: An undervoltage flag on a rail that is not enabled does not set the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_pgood | input | 1 | Standby supply past its power-on threshold |
| p12_pgood | input | 1 | 12 V supply good |
| slp_s3 | input | 1 | Sleep pin, low selects a deep state |
| slp_s5 | input | 1 | Sleep pin, low selects soft-off |
| strap_d3 | input | 1 | Keep 3.3 V dual plane in soft-off |
| strap_d5 | input | 1 | Keep 5 V dual plane in sleep states |
| mem_sel | input | 1 | Memory voltage select, 1 = higher setting |
| uv | input | 5 | Undervoltage flags per rail |
| sb_en | output | 1 | Always-on standby rail enable |
| act_en | output | 4 | Active-path enables per plane |
| slp_en | output | 4 | Sleep-path enables per plane |
| mem_hi_v | output | 1 | Latched memory voltage select |
| fault | output | 1 | Sticky fault |

## Verification
For every combination of straps and memory select, the bench walks a sequence of pin codes that includes the reserved code and both forbidden sleep-to-sleep moves. A design that decoded code 01 or honoured those moves would show a plane turned on or off that should have held. The bench flips the strap pins after capture and checks the startup window one cycle on each side of the capture edge, which catches a design that tracks the pins live or opens the planes early. It also checks the gap cycle in a path handover, the 12 V gate, the sticky fault and its clearing, and undervoltage flags on disabled rails. These catch an overlap of the two paths, a fault that clears itself, or a fault raised by a rail that is switched off.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [1:0] {
      PST_ON   = 2'd0,
      PST_RAM  = 2'd1,
      PST_SOFT = 2'd2
   } pwr_st_e;

   localparam int unsigned RAIL_D3  = 0;
   localparam int unsigned RAIL_D5  = 1;
   localparam int unsigned RAIL_MEM = 2;
   localparam int unsigned RAIL_CLK = 3;
   localparam int unsigned N_SW     = 4;
   localparam int unsigned N_UV     = N_SW + 1;

   // Pin decode with hold on the reserved code and no sleep-to-sleep moves
   function automatic pwr_st_e next_st(pwr_st_e cur, logic s5, logic s3);
      pwr_st_e nx;
      nx = cur;
      case ({s5, s3})
         2'b11:   nx = PST_ON;
         2'b10:   if (cur != PST_SOFT) nx = PST_RAM;
         2'b00:   if (cur != PST_RAM)  nx = PST_SOFT;
         default: nx = cur;
      endcase
      return nx;
   endfunction

endpackage

// File: rtl/rail_state_track.sv
module rail_state_track
   import rail_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pin_s3,
   input  logic    pin_s5,
   output pwr_st_e st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PST_SOFT;
      else        st <= next_st(st, pin_s5, pin_s3);
   end

   AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_s5 && pin_s3) |=> $stable(st)); // R1
   AST_RUN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_s5 && pin_s3) |=> (st == PST_ON)); // R1
   AST_NO_RAM_TO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PST_RAM) |=> (st != PST_SOFT)); // R2
   AST_NO_SOFT_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PST_SOFT) |=> (st != PST_RAM)); // R2

endmodule

// File: rtl/rail_cfg_latch.sv
module rail_cfg_latch #(
   parameter int unsigned CLK_KHZ  = 200000,
   parameter int unsigned DELAY_MS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sb_pgood,
   input  logic       strap_d3,
   input  logic       strap_d5,
   input  logic       mem_sel,
   output logic       done,
   output logic [2:0] cfg
);

   localparam int unsigned WAIT_CYC = CLK_KHZ * DELAY_MS;
   localparam int unsigned CW       = $clog2(WAIT_CYC + 1);

   logic [CW-1:0] cnt;

   initial begin
      assert (CLK_KHZ > 0 && DELAY_MS > 0)
         else $error("rail_cfg_latch: CLK_KHZ and DELAY_MS must be nonzero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
         cfg  <= '0;
      end else if (!sb_pgood) begin
         cnt  <= '0;
         done <= 1'b0;
         cfg  <= '0;
      end else if (!done) begin
         if (cnt == CW'(WAIT_CYC - 1)) begin
            done <= 1'b1;
            cfg  <= {mem_sel, strap_d5, strap_d3};
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(cfg)); // R8
   AST_DONE_NEEDS_SB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(sb_pgood)); // R8

endmodule

// File: rtl/rail_path_pair.sv
module rail_path_pair #(
   parameter bit BBM = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_req,
   input  logic slp_req,
   output logic act_en,
   output logic slp_en
);

   if (BBM) begin : g_bbm
      // each path may only rise once the other was already off
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_en <= 1'b0;
            slp_en <= 1'b0;
         end else begin
            act_en <= act_req & ~slp_en;
            slp_en <= slp_req & ~act_en;
         end
      end

      AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(act_en && slp_en)); // R9
      AST_GAP_TO_SLP: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(slp_en) |-> !$past(act_en)); // R9
      AST_GAP_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(act_en) |-> !$past(slp_en)); // R9
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_en <= 1'b0;
            slp_en <= 1'b0;
         end else begin
            act_en <= act_req;
            slp_en <= slp_req & ~act_req;
         end
      end

      AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(act_en && slp_en)); // R9
   end

endmodule

// File: rtl/acpi_rail_seq.sv
module acpi_rail_seq
   import rail_seq_pkg::*;
#(
   parameter int unsigned CLK_KHZ  = 200000,
   parameter int unsigned DELAY_MS = 3,
   parameter bit          BBM      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sb_pgood,
   input  logic       p12_pgood,
   input  logic       slp_s3,
   input  logic       slp_s5,
   input  logic       strap_d3,
   input  logic       strap_d5,
   input  logic       mem_sel,
   input  logic [4:0] uv,
   output logic       sb_en,
   output logic [3:0] act_en,
   output logic [3:0] slp_en,
   output logic       mem_hi_v,
   output logic       fault
);

   initial begin
      assert (N_SW == 4 && N_UV == 5)
         else $error("acpi_rail_seq: rail count does not match port widths");
   end

   pwr_st_e         st;
   logic            cfg_done;
   logic [2:0]      cfg;
   logic [N_SW-1:0] act_want, slp_want, act_req, slp_req;
   logic            gate;
   logic [N_UV-1:0] rail_on;

   rail_state_track u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_s3 (slp_s3),
      .pin_s5 (slp_s5),
      .st     (st)
   );

   rail_cfg_latch #(.CLK_KHZ(CLK_KHZ), .DELAY_MS(DELAY_MS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sb_pgood (sb_pgood),
      .strap_d3 (strap_d3),
      .strap_d5 (strap_d5),
      .mem_sel  (mem_sel),
      .done     (cfg_done),
      .cfg      (cfg)
   );

   always_comb begin
      act_want           = {N_SW{st == PST_ON}};
      slp_want           = '0;
      slp_want[RAIL_D3]  = (st == PST_RAM) | ((st == PST_SOFT) & cfg[0]);
      slp_want[RAIL_D5]  = (st != PST_ON) & cfg[1];
      slp_want[RAIL_MEM] = (st == PST_RAM);
      gate               = sb_pgood & cfg_done & ~fault;
      act_req            = act_want & {N_SW{gate & p12_pgood}};
      slp_req            = slp_want & {N_SW{gate}};
   end

   for (genvar r = 0; r < N_SW; r++) begin : g_rail
      rail_path_pair #(.BBM(BBM)) u_path (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_req (act_req[r]),
         .slp_req (slp_req[r]),
         .act_en  (act_en[r]),
         .slp_en  (slp_en[r])
      );
   end

   assign rail_on  = {sb_en, act_en | slp_en};
   assign mem_hi_v = cfg[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_en <= 1'b0;
         fault <= 1'b0;
      end else begin
         sb_en <= sb_pgood;
         if (!sb_pgood)              fault <= 1'b0;
         else if (|(uv & rail_on))   fault <= 1'b1;
      end
   end

   AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && sb_pgood) |=> (act_en == '0 && slp_en == '0)); // R11
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && sb_pgood) |=> fault); // R11
   AST_CLK_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      act_en[RAIL_CLK] |-> ($past(st) == PST_ON)); // R6
   AST_MEM_SLP_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      slp_en[RAIL_MEM] |-> ($past(st) == PST_RAM)); // R5
   AST_ACT_NEEDS_12V: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en != '0) |-> $past(p12_pgood)); // R10
   AST_NO_EN_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_en | slp_en) != '0) |-> $past(cfg_done)); // R8

endmodule

// File: tb/acpi_rail_seq_test.sv
module acpi_rail_seq_test;

   localparam int unsigned CLK_KHZ  = 4;
   localparam int unsigned DELAY_MS = 3;
   localparam int unsigned WAIT_CYC = CLK_KHZ * DELAY_MS;

   logic       clk = 1'b0;
   logic       rst_n, sb_pgood, p12_pgood, slp_s3, slp_s5;
   logic       strap_d3, strap_d5, mem_sel;
   logic [4:0] uv;
   logic       sb_en, mem_hi_v, fault;
   logic [3:0] act_en, slp_en;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   acpi_rail_seq #(.CLK_KHZ(CLK_KHZ), .DELAY_MS(DELAY_MS), .BBM(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sb_pgood(sb_pgood), .p12_pgood(p12_pgood),
      .slp_s3(slp_s3), .slp_s5(slp_s5), .strap_d3(strap_d3), .strap_d5(strap_d5),
      .mem_sel(mem_sel), .uv(uv), .sb_en(sb_en), .act_en(act_en), .slp_en(slp_en),
      .mem_hi_v(mem_hi_v), .fault(fault)
   );

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pins(int code);
      slp_s5 = code[1];
      slp_s3 = code[0];
   endtask

   // 0 = running, 1 = suspend-to-RAM, 2 = soft-off
   function automatic int model_next(int cur, int code);
      if (code == 3) return 0;
      if (code == 2) return (cur == 2) ? cur : 1;
      if (code == 0) return (cur == 1) ? cur : 2;
      return cur;
   endfunction

   function automatic logic [3:0] exp_act(int st);
      return (st == 0) ? 4'hF : 4'h0;
   endfunction

   function automatic logic [3:0] exp_slp(int st, bit e3, bit e5);
      logic [3:0] s;
      s[0] = (st == 1) || (st == 2 && e3);
      s[1] = (st != 0) && e5;
      s[2] = (st == 1);
      s[3] = 1'b0;
      return s;
   endfunction

   // no plane may ever enable both paths
   always @(negedge clk) begin
      if (rst_n === 1'b1 && (act_en & slp_en) != 4'h0) begin
         errors++;
         $display("FAIL R9 path overlap: actual %0h expected 0", act_en & slp_en);
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seq [14] = '{3, 2, 3, 0, 2, 3, 1, 2, 0, 1, 3, 0, 1, 3};
      int st;
      logic [3:0] ea, es;
      rst_n = 1'b0; sb_pgood = 1'b0; p12_pgood = 1'b1; uv = '0;
      strap_d3 = 1'b0; strap_d5 = 1'b0; mem_sel = 1'b0;
      pins(0);

      for (int cfgi = 0; cfgi < 8; cfgi++) begin
         bit e3, e5, ms;
         e3 = cfgi[0]; e5 = cfgi[1]; ms = cfgi[2];
         rst_n = 1'b0; sb_pgood = 1'b0; pins(0);
         strap_d3 = e3; strap_d5 = e5; mem_sel = ms;
         step(2);
         chk(sb_en == 0 && act_en == 0 && slp_en == 0 && fault == 0, "R7",
             "reset state", {sb_en, act_en, slp_en, fault}, 0);
         rst_n = 1'b1;
         step(2);
         chk(sb_en == 0, "R7", "standby rail off without sb_pgood", sb_en, 0);
         sb_pgood = 1'b1;
         step(WAIT_CYC - 1);
         chk(act_en == 0 && slp_en == 0 && mem_hi_v == 0, "R8",
             "nothing before capture edge", {act_en, slp_en, mem_hi_v}, 0);
         chk(sb_en == 1, "R7", "standby rail on", sb_en, 1);
         step(1);
         chk(mem_hi_v == ms, "R8", "select captured", mem_hi_v, ms);
         chk(act_en == 0 && slp_en == 0, "R8", "planes wait one edge after capture",
             {act_en, slp_en}, 0);
         step(1);
         st = 2;
         chk(slp_en == exp_slp(st, e3, e5), "R3", "soft-off straps after startup",
             slp_en, exp_slp(st, e3, e5));
         // pins change after capture: must not matter
         strap_d3 = ~e3; strap_d5 = ~e5; mem_sel = ~ms;
         foreach (seq[i]) begin
            string kind;
            int nst;
            nst = model_next(st, seq[i]);
            kind = (seq[i] == 1) ? "R1 reserved hold" :
                   (nst == st && seq[i] != 3) ? "R2 refused move" : "R1 decode";
            st = nst;
            pins(seq[i]);
            step(4);
            ea = exp_act(st);
            es = exp_slp(st, e3, e5);
            chk({act_en[0], slp_en[0]} == {ea[0], es[0]}, "R3", kind,
                {act_en[0], slp_en[0]}, {ea[0], es[0]});
            chk({act_en[1], slp_en[1]} == {ea[1], es[1]}, "R4", kind,
                {act_en[1], slp_en[1]}, {ea[1], es[1]});
            chk({act_en[2], slp_en[2], mem_hi_v} == {ea[2], es[2], ms}, "R5", kind,
                {act_en[2], slp_en[2], mem_hi_v}, {ea[2], es[2], ms});
            chk({act_en[3], slp_en[3]} == {ea[3], 1'b0}, "R6", kind,
                {act_en[3], slp_en[3]}, {ea[3], 1'b0});
            chk(sb_en == 1 && fault == 0, "R7", "standby rail independent of pins",
                {sb_en, fault}, 2);
         end
      end

      // last config latched e3=e5=ms=1, now running; strap pins read 0
      pins(2);
      step(2);
      chk(act_en == 0 && slp_en == 0, "R9", "gap cycle on handover",
          {act_en, slp_en}, 0);
      step(1);
      chk(slp_en == 4'b0111, "R9", "sleep paths after gap", slp_en, 4'b0111);
      pins(3);
      step(4);
      chk(act_en == 4'hF && slp_en == 0, "R9", "back to active paths",
          {act_en, slp_en}, 8'hF0);

      p12_pgood = 1'b0;
      step(1);
      chk(act_en == 0, "R10", "active paths drop without 12V", act_en, 0);
      chk(sb_en == 1, "R10", "standby rail kept without 12V", sb_en, 1);
      p12_pgood = 1'b1;
      step(2);
      chk(act_en == 4'hF, "R10", "active paths return with 12V", act_en, 4'hF);

      uv = 5'b00100;
      step(1);
      chk(fault == 1, "R11", "fault from enabled memory rail", fault, 1);
      uv = '0;
      step(1);
      chk(act_en == 0 && slp_en == 0, "R11", "planes off under fault",
          {act_en, slp_en}, 0);
      pins(2);
      step(4);
      chk(fault == 1 && act_en == 0 && slp_en == 0, "R11", "fault sticky",
          {fault, act_en, slp_en}, 9'h100);
      sb_pgood = 1'b0;
      step(1);
      chk(fault == 0 && sb_en == 0, "R11", "fault cleared by standby loss",
          {fault, sb_en}, 0);

      // re-capture takes current pins 0,0,0; state is suspend-to-RAM
      sb_pgood = 1'b1;
      step(WAIT_CYC + 4);
      chk(slp_en == 4'b0101 && act_en == 0, "R8", "re-capture after standby loss",
          {act_en, slp_en}, 8'h05);
      chk(mem_hi_v == 0, "R8", "select re-captured", mem_hi_v, 0);

      uv = 5'b01010;
      step(3);
      chk(fault == 0, "R12", "flags on disabled rails ignored", fault, 0);
      chk(slp_en == 4'b0101, "R12", "planes unaffected", slp_en, 4'b0101);
      uv = 5'b10000;
      step(2);
      chk(fault == 1, "R11", "fault from standby rail", fault, 1);
      uv = '0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule